// File: doc/BRIEF.md
# Video Raster Sync Generator

This block supplies the line and field timebase of a television-standard video encoder and drives, or listens to, two raster control ports. In master mode a horizontal sample counter and a line counter run freely from a pixel-rate clock enable. Port A then carries one of four vertical-type signals: a vertical sync window that starts two and a half lines into the field, the same window starting three lines in, a field flag, or a four-field sequence flag. Port B carries a horizontal pulse whose start and end samples are set by configuration. Each port output has its own polarity control.

In slave mode the counters coast between reloads. An edge of the configured polarity on port A reloads them after a configured number of sample enables. The horizontal phase can come from an edge on port B instead. In that case port A sets the line only. When port A supplies both phases, port B stays an output and carries the horizontal window as a blanking signal. Output enables model the bidirectional pins. All configuration is static input. No pixel data passes through the block, so it has no valid/ready interface: every pin is a plain level. `h_pos` and `line_pos` expose the timebase so the video data port can be aligned to the sync outputs.

Top module: `raster_sync_gen`

## Requirements
- R1: Reset puts `h_pos` and `line_pos` at 0. Each cycle with `pix_en` high advances `h_pos` by one. From LINE_LEN-1 it wraps to 0 and advances `line_pos`, which wraps from FRAME_LINES-1 to 0. With `pix_en` low both counters hold.
- R2: `cfg_vmode`=0 (half-line vertical sync): the active level of port A spans field-relative line 2 sample LINE_LEN/2 up to, but not including, line 2+VS_LINES at sample LINE_LEN/2. Field two starts at line (FRAME_LINES+1)/2, and field-relative lines count from there.
- R3: `cfg_vmode`=1 (full-line vertical sync): port A is active from field-relative line 3 sample 0 up to, but not including, line 3+VS_LINES sample 0.
- R4: `cfg_vmode`=2 (field flag): port A is active on every line below (FRAME_LINES+1)/2 and inactive on the others.
- R5: `cfg_vmode`=3 (field sequence): port A is active only in field one of the first frame after reset and of every second frame after it, which is one field in four.
- R6: Port B's horizontal pulse is active for `cfg_hs_start` <= `h_pos` < `cfg_hs_end`. When start > end the pulse wraps through sample 0. When start equals end it is never active.
- R7: `cfg_pa_inv`=1 inverts port A's output and `cfg_pb_inv`=1 inverts port B's output. With the bit at 1 the active level is low.
- R8: `pa_oe` is 1 only in master mode. `pb_oe` is 1 in master mode, and in slave mode when `cfg_h_from_pb`=0.
- R9: In slave mode with `cfg_h_from_pb`=0, an active edge on `pa_in` sampled at enable E sets both counters to 0 at enable E+`cfg_sync_delay`. The active edge is a rise of `pa_in` XOR `cfg_pa_inv`.
- R10: In slave mode with `cfg_h_from_pb`=1, an active edge on `pb_in` reloads only `h_pos` to 0 after the same delay, and an edge on `pa_in` reloads only `line_pos` to 0. An active edge on `pb_in` is a rise of `pb_in` XOR `cfg_pb_inv`.
- R11: A reload takes priority over the counter's own step. A horizontal reload at sample LINE_LEN-1 leaves `line_pos` unchanged. Horizontal and line reloads in the same enable give position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Sample-rate clock enable |
| cfg_master | input | 1 | 1 = free-running master, 0 = slave |
| cfg_vmode | input | 2 | Port A signal select: 0 half-line vsync, 1 full-line vsync, 2 field flag, 3 field sequence |
| cfg_pa_inv | input | 1 | Port A polarity (output and slave input) |
| cfg_pb_inv | input | 1 | Port B polarity (output and slave input) |
| cfg_h_from_pb | input | 1 | Slave: horizontal phase from port B |
| cfg_hs_start | input | HW | First sample of port B pulse |
| cfg_hs_end | input | HW | Sample after the last one of port B pulse |
| cfg_sync_delay | input | DLY_W | Slave reload delay in enables |
| pa_in | input | 1 | Port A pin input |
| pa_out | output | 1 | Port A pin output value |
| pa_oe | output | 1 | Port A driver enable |
| pb_in | input | 1 | Port B pin input |
| pb_out | output | 1 | Port B pin output value |
| pb_oe | output | 1 | Port B driver enable |
| h_pos | output | HW | Current sample within the line |
| line_pos | output | LW | Current line within the frame |

## Verification
Two slave reloads can land on the same enable, and either reload can coincide with the counter's own wrap. The bench places a port B edge exactly at the last sample of a line and expects the line number to stay put. It then raises edges on both ports in the same enable at the last sample, and expects (0,0) rather than a line increment. On the master side, the pulse bounds are tested at the same sample where the vertical window opens or closes, so both port decodes are judged against one counter value.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic [1:0] {
    PA_VS_HALF  = 2'd0,
    PA_VS_FULL  = 2'd1,
    PA_FIELD    = 2'd2,
    PA_SEQ      = 2'd3
  } pa_sel_e;
endpackage

// File: rtl/rsg_edge_reload.sv
// Detects an active edge on a raster input and fires a reload strobe a
// programmable number of enables later (immediately for a delay of zero).
module rsg_edge_reload #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act,
  input  logic             pin,
  input  logic             inv,
  input  logic [DLY_W-1:0] delay,
  output logic             fire
);
  logic             lvl, prev_q, busy_q, edge_seen;
  logic [DLY_W-1:0] cnt_q;

  assign lvl       = pin ^ inv;
  assign edge_seen = act && lvl && !prev_q;
  assign fire      = en && act &&
                     ((edge_seen && delay == '0) ||
                      (!edge_seen && busy_q && cnt_q == DLY_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      prev_q <= lvl;
      if (edge_seen) begin
        busy_q <= (delay != '0);
        cnt_q  <= delay;
      end else if (busy_q) begin
        cnt_q <= cnt_q - DLY_W'(1);
        if (cnt_q == DLY_W'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsg_timebase.sv
// Sample and line counters with frame parity; reloads override the step.
module rsg_timebase #(
  parameter int LINE_LEN    = 864,
  parameter int FRAME_LINES = 625,
  localparam int HW = $clog2(LINE_LEN),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reload_h,
  input  logic          reload_l,
  output logic [HW-1:0] h_q,
  output logic [LW-1:0] l_q,
  output logic          fpar_q
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_LEN - 1);
  localparam logic [LW-1:0] L_LAST = LW'(FRAME_LINES - 1);

  logic h_wrap;
  assign h_wrap = (h_q == H_LAST) && !reload_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q    <= '0;
      l_q    <= '0;
      fpar_q <= 1'b0;
    end else if (en) begin
      if (reload_h || h_q == H_LAST) h_q <= '0;
      else                           h_q <= h_q + HW'(1);

      if (reload_l) begin
        l_q <= '0;
      end else if (h_wrap) begin
        if (l_q == L_LAST) begin
          l_q    <= '0;
          fpar_q <= ~fpar_q;
        end else begin
          l_q <= l_q + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rsg_port_decode.sv
// Decodes the port A vertical-type signal and the port B horizontal pulse.
module rsg_port_decode
  import rsg_pkg::*;
#(
  parameter int LINE_LEN    = 864,
  parameter int FRAME_LINES = 625,
  parameter int VS_LINES    = 3,
  localparam int HW = $clog2(LINE_LEN),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic [HW-1:0] h,
  input  logic [LW-1:0] l,
  input  logic          fpar,
  input  logic [1:0]    vmode,
  input  logic          inv_a,
  input  logic          inv_b,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_end,
  output logic          pa_val,
  output logic          pb_val
);
  localparam int FLD2 = (FRAME_LINES + 1) / 2;
  localparam int HALF = LINE_LEN / 2;

  function automatic logic at_or_after(int ln, int hp, int ref_l, int ref_h);
    return (ln > ref_l) || (ln == ref_l && hp >= ref_h);
  endfunction

  logic act_a, act_b;

  always_comb begin
    int li, hi, rel;
    logic first_field;
    li          = int'(l);
    hi          = int'(h);
    first_field = (li < FLD2);
    rel         = first_field ? li : li - FLD2;
    unique case (pa_sel_e'(vmode))
      PA_VS_HALF: act_a = at_or_after(rel, hi, 2, HALF) &&
                          !at_or_after(rel, hi, 2 + VS_LINES, HALF);
      PA_VS_FULL: act_a = at_or_after(rel, hi, 3, 0) &&
                          !at_or_after(rel, hi, 3 + VS_LINES, 0);
      PA_FIELD:   act_a = first_field;
      default:    act_a = first_field && !fpar;
    endcase

    if (hs_start < hs_end)      act_b = (h >= hs_start) && (h < hs_end);
    else if (hs_start > hs_end) act_b = (h >= hs_start) || (h < hs_end);
    else                        act_b = 1'b0;
  end

  assign pa_val = act_a ^ inv_a;
  assign pb_val = act_b ^ inv_b;
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
  parameter int LINE_LEN    = 864,
  parameter int FRAME_LINES = 625,
  parameter int VS_LINES    = 3,
  parameter int DLY_W       = 8,
  localparam int HW = $clog2(LINE_LEN),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             cfg_master,
  input  logic [1:0]       cfg_vmode,
  input  logic             cfg_pa_inv,
  input  logic             cfg_pb_inv,
  input  logic             cfg_h_from_pb,
  input  logic [HW-1:0]    cfg_hs_start,
  input  logic [HW-1:0]    cfg_hs_end,
  input  logic [DLY_W-1:0] cfg_sync_delay,
  input  logic             pa_in,
  output logic             pa_out,
  output logic             pa_oe,
  input  logic             pb_in,
  output logic             pb_out,
  output logic             pb_oe,
  output logic [HW-1:0]    h_pos,
  output logic [LW-1:0]    line_pos
);
  logic fire_a, fire_b, fpar;
  logic slave_a, slave_b;

  assign slave_a = !cfg_master;
  assign slave_b = !cfg_master && cfg_h_from_pb;

  rsg_edge_reload #(.DLY_W(DLY_W)) u_rel_a (
    .clk(clk), .rst_n(rst_n), .en(pix_en), .act(slave_a),
    .pin(pa_in), .inv(cfg_pa_inv), .delay(cfg_sync_delay), .fire(fire_a)
  );

  rsg_edge_reload #(.DLY_W(DLY_W)) u_rel_b (
    .clk(clk), .rst_n(rst_n), .en(pix_en), .act(slave_b),
    .pin(pb_in), .inv(cfg_pb_inv), .delay(cfg_sync_delay), .fire(fire_b)
  );

  rsg_timebase #(.LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(pix_en),
    .reload_h(cfg_h_from_pb ? fire_b : fire_a),
    .reload_l(fire_a),
    .h_q(h_pos), .l_q(line_pos), .fpar_q(fpar)
  );

  rsg_port_decode #(.LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES),
                    .VS_LINES(VS_LINES)) u_dec (
    .h(h_pos), .l(line_pos), .fpar(fpar), .vmode(cfg_vmode),
    .inv_a(cfg_pa_inv), .inv_b(cfg_pb_inv),
    .hs_start(cfg_hs_start), .hs_end(cfg_hs_end),
    .pa_val(pa_out), .pb_val(pb_out)
  );

  assign pa_oe = cfg_master;
  assign pb_oe = cfg_master || !cfg_h_from_pb;
endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk #(
  parameter int LINE_LEN    = 864,
  parameter int FRAME_LINES = 625,
  localparam int HW = $clog2(LINE_LEN),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          cfg_master,
  input logic          cfg_h_from_pb,
  input logic          cfg_pb_inv,
  input logic [HW-1:0] cfg_hs_start,
  input logic [HW-1:0] cfg_hs_end,
  input logic          pa_oe,
  input logic          pb_oe,
  input logic          pb_out,
  input logic [HW-1:0] h_pos,
  input logic [LW-1:0] line_pos
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_LEN - 1);

  // R1
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(h_pos) < LINE_LEN) && (int'(line_pos) < FRAME_LINES));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(h_pos) && $stable(line_pos));

  // R1
  master_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && pix_en && h_pos != H_LAST |=> h_pos == $past(h_pos) + HW'(1));

  // R1
  master_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && pix_en && h_pos == H_LAST |=> h_pos == '0);

  // R8
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == cfg_master) && (pb_oe == (cfg_master || !cfg_h_from_pb)));

  // R6
  empty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_oe && cfg_hs_start == cfg_hs_end |-> pb_out == cfg_pb_inv);
endmodule

bind raster_sync_gen raster_sync_gen_chk #(
  .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_master(cfg_master),
  .cfg_h_from_pb(cfg_h_from_pb), .cfg_pb_inv(cfg_pb_inv),
  .cfg_hs_start(cfg_hs_start), .cfg_hs_end(cfg_hs_end),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pb_out(pb_out),
  .h_pos(h_pos), .line_pos(line_pos)
);

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;
  // Small raster: 16 samples x 10 lines, field two from line 5, 2-line vsync.
  localparam int LL = 16;
  localparam int FL = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       cfg_master = 1'b1;
  logic [1:0] cfg_vmode = 2'd0;
  logic       cfg_pa_inv = 1'b0, cfg_pb_inv = 1'b0, cfg_h_from_pb = 1'b0;
  logic [3:0] cfg_hs_start = 4'd4, cfg_hs_end = 4'd9;
  logic [7:0] cfg_sync_delay = 8'd0;
  logic       pa_in = 1'b0, pb_in = 1'b0;
  logic       pa_out, pa_oe, pb_out, pb_oe;
  logic [3:0] h_pos, line_pos;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  raster_sync_gen #(.LINE_LEN(LL), .FRAME_LINES(FL), .VS_LINES(2), .DLY_W(8))
  u_raster_sync_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_master(cfg_master),
    .cfg_vmode(cfg_vmode), .cfg_pa_inv(cfg_pa_inv), .cfg_pb_inv(cfg_pb_inv),
    .cfg_h_from_pb(cfg_h_from_pb), .cfg_hs_start(cfg_hs_start),
    .cfg_hs_end(cfg_hs_end), .cfg_sync_delay(cfg_sync_delay),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .h_pos(h_pos), .line_pos(line_pos)
  );

  typedef struct packed {
    logic       fr;
    logic [3:0] ln;
    logic [3:0] hp;
    logic [1:0] vm;
    logic       ia, ib;
    logic [3:0] hs, he;
    logic       ea, eb;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{1'b0, 4'd2, 4'd7,  2'd0, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b1}, // R2 before open
    '{1'b0, 4'd2, 4'd8,  2'd0, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b1}, // R2 opens
    '{1'b0, 4'd4, 4'd7,  2'd0, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b1}, // R2 last
    '{1'b0, 4'd4, 4'd8,  2'd0, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b1}, // R2 closed
    '{1'b0, 4'd7, 4'd8,  2'd0, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b1}, // R2 field two
    '{1'b0, 4'd3, 4'd0,  2'd1, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b0}, // R3 opens
    '{1'b0, 4'd2, 4'd15, 2'd1, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b0}, // R3 before
    '{1'b0, 4'd5, 4'd0,  2'd1, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b0}, // R3 closed
    '{1'b0, 4'd8, 4'd0,  2'd1, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b0}, // R3 field two
    '{1'b0, 4'd4, 4'd9,  2'd2, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b0}, // R4 / R6 end excl
    '{1'b0, 4'd5, 4'd0,  2'd2, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b0}, // R4 field two
    '{1'b0, 4'd1, 4'd3,  2'd3, 1'b0, 1'b0, 4'd4,  4'd9, 1'b1, 1'b0}, // R5 frame 0
    '{1'b1, 4'd1, 4'd3,  2'd3, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b0}, // R5 frame 1
    '{1'b0, 4'd6, 4'd3,  2'd3, 1'b0, 1'b0, 4'd4,  4'd9, 1'b0, 1'b0}, // R5 field two
    '{1'b0, 4'd4, 4'd4,  2'd2, 1'b1, 1'b1, 4'd4,  4'd9, 1'b0, 1'b0}, // R7 both inverted
    '{1'b0, 4'd0, 4'd14, 2'd2, 1'b0, 1'b0, 4'd12, 4'd3, 1'b1, 1'b1}, // R6 wrap high
    '{1'b0, 4'd0, 4'd5,  2'd2, 1'b0, 1'b0, 4'd12, 4'd3, 1'b1, 1'b0}, // R6 wrap gap
    '{1'b0, 4'd0, 4'd6,  2'd2, 1'b0, 1'b0, 4'd6,  4'd6, 1'b1, 1'b0}  // R6 empty
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    pix_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Exactly n enables, starting and ending on a falling edge.
  task automatic adv(input int n);
    if (n > 0) begin
      pix_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      pix_en = 1'b0;
    end
  endtask

  task automatic pos_chk(input string tag, input int l, input int h);
    chk({tag, " line"}, int'(line_pos), l);
    chk({tag, " sample"}, int'(h_pos), h);
  endtask

  initial begin
    // R1 reset state and R8 master enables
    cfg_master = 1'b1;
    do_reset();
    pos_chk("R1 reset", 0, 0);
    chk("R8 master pa_oe", int'(pa_oe), 1);
    chk("R8 master pb_oe", int'(pb_oe), 1);

    // R1 hold with pix_en low, then step and frame wrap
    repeat (4) @(negedge clk);
    pos_chk("R1 hold", 0, 0);
    adv(LL - 1);
    pos_chk("R1 line end", 0, 15);
    adv(1);
    pos_chk("R1 line wrap", 1, 0);
    adv(LL * FL - LL);
    pos_chk("R1 frame wrap", 0, 0);

    // Vector table: master decode at chosen positions
    foreach (VECS[i]) begin
      cfg_vmode    = VECS[i].vm;
      cfg_pa_inv   = VECS[i].ia;
      cfg_pb_inv   = VECS[i].ib;
      cfg_hs_start = VECS[i].hs;
      cfg_hs_end   = VECS[i].he;
      do_reset();
      adv(int'(VECS[i].fr) * LL * FL + int'(VECS[i].ln) * LL + int'(VECS[i].hp));
      chk($sformatf("vec %0d port A", i), int'(pa_out), int'(VECS[i].ea));
      chk($sformatf("vec %0d port B", i), int'(pb_out), int'(VECS[i].eb));
      pos_chk($sformatf("vec %0d R1", i), int'(VECS[i].ln), int'(VECS[i].hp));
    end

    // R9 slave reload from port A, active low, delay 3
    cfg_master = 1'b0; cfg_h_from_pb = 1'b0; cfg_pa_inv = 1'b1;
    cfg_pb_inv = 1'b0; cfg_sync_delay = 8'd3; pa_in = 1'b1;
    cfg_hs_start = 4'd4; cfg_hs_end = 4'd9;
    do_reset();
    chk("R8 slave pa_oe", int'(pa_oe), 0);
    chk("R8 slave pb_oe (blanking out)", int'(pb_oe), 1);
    adv(20);
    pos_chk("R9 coast", 1, 4);
    pa_in = 1'b0;
    adv(1);
    pos_chk("R9 edge enable", 1, 5);
    adv(2);
    pos_chk("R9 delay pending", 1, 7);
    adv(1);
    pos_chk("R9 reloaded", 0, 0);
    adv(1);
    pos_chk("R9 runs after reload", 0, 1);

    // R10 / R11 horizontal phase from port B, delay 0
    cfg_h_from_pb = 1'b1; cfg_pa_inv = 1'b0; cfg_sync_delay = 8'd0;
    pa_in = 1'b0; pb_in = 1'b0;
    do_reset();
    chk("R8 slave pb_oe (input)", int'(pb_oe), 0);
    adv(35);
    pos_chk("R10 coast", 2, 3);
    pb_in = 1'b1;
    adv(1);
    pb_in = 1'b0;
    pos_chk("R10 port B reload", 2, 0);
    adv(15);
    pb_in = 1'b1;
    adv(1);
    pb_in = 1'b0;
    pos_chk("R11 reload at line end", 2, 0);
    adv(15);
    pos_chk("R11 setup", 2, 15);
    pb_in = 1'b1; pa_in = 1'b1;
    adv(1);
    pb_in = 1'b0; pa_in = 1'b0;
    pos_chk("R11 both reloads", 0, 0);
    adv(3);
    pa_in = 1'b1;
    adv(1);
    pa_in = 1'b0;
    pos_chk("R10 port A line only", 0, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule